// File: doc/BRIEF.md
# Digit-Serial Decimal Adder-Subtractor with Sign Recovery

The block adds or subtracts two unsigned packed decimal operands of eight digits. It processes one digit per clock, starting at the least significant digit. For each digit it forms the binary sum and corrects it back into the 0 to 9 range. The carry from each digit feeds the digit above it.

Subtraction A − B adds the ten's complement of B. The +1 of the complement enters as the carry into the first digit. When no carry leaves the top digit, the raw sum is a complemented negative value. A second digit-serial pass then takes its ten's complement, so the block returns a magnitude and a negative flag rather than a complement code. A carry out of the top digit during an addition raises an overflow flag.

A caller drives the operands and the mode, pulses start for one cycle, and waits for the one-cycle done pulse. The result and the flags stay unchanged until the next operation completes.

Top module: `bcd_addsub`

States:
- `ST_IDLE` waits for start.
- `ST_MAIN_PASS` runs the add or complement-add over all digits.
- `ST_RECOMP_PASS` re-complements a negative raw sum.

Transitions:
- Launch: `ST_IDLE` to `ST_MAIN_PASS` on start.
- Step: a pass state stays where it is until its last digit.
- Finish: `ST_MAIN_PASS` to `ST_IDLE` at the last digit when no recomplement is needed.
- Borrow: `ST_MAIN_PASS` to `ST_RECOMP_PASS` at the last digit of a subtraction with no end carry.
- Settle: `ST_RECOMP_PASS` to `ST_IDLE` at its last digit.

## Requirements
- R1: Operand digit i occupies bits [4i+3:4i], digit 0 being least significant, each holding 0 to 9. Every digit step adds the two digits and the incoming carry in binary. When that sum exceeds 9, 6 is added, the low four bits become the digit and the carry out is 1. Every result digit is therefore 0 to 9.
- R2: Carries move from digit 0 upward, one digit per cycle, so a carry born in digit 0 can change every higher digit (for example 99999999 + 1 gives 00000000).
- R3: With sub = 1 and A ≥ B, the result is A − B and negative is 0. The ten's complement of B is formed as 9 − digit with a carry of 1 into digit 0, and the end carry is dropped.
- R4: With sub = 1 and A < B, the result is B − A and negative is 1. Done comes 16 cycles after the clock edge that accepted start.
- R5: A subtraction whose operands are equal returns result zero with negative = 0, after 8 cycles.
- R6: With sub = 0, a carry out of the top digit sets overflow to 1, and the result holds the low eight digits of the sum. Subtraction never sets overflow.
- R7: For additions and non-negative subtractions, done is a one-cycle pulse 8 cycles after the accepting edge.
- R8: A start asserted while an operation is running is ignored. The running operation's result and timing are unaffected.
- R9: After reset, result, negative, overflow and done are 0. After done, result and flags hold their values until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| sub | input | 1 | 0 = A + B, 1 = A − B |
| opa | input | 32 | Operand A, packed decimal |
| opb | input | 32 | Operand B, packed decimal |
| result | output | 32 | Result magnitude, packed decimal |
| negative | output | 1 | Result is negative |
| overflow | output | 1 | Addition carried out of the top digit |
| done | output | 1 | One-cycle completion pulse |

## Verification
The digit-range assertions assume that every operand nibble lies in 0 to 9. A nibble of 10 or more would leave the corrected sum and the nine's complement outside the decimal range. The stimulus therefore builds every operand from integers below 10^8 and converts them digit by digit, so no out-of-range nibble reaches the block. The control assertions assume start is a single-cycle pulse. The bench holds it for exactly one cycle, including the extra pulse it injects mid-operation.

// File: rtl/bcd_addsub_pkg.sv
package bcd_addsub_pkg;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_MAIN_PASS   = 2'd1,
        ST_RECOMP_PASS = 2'd2
    } seq_state_t;

    localparam logic [3:0] DIGIT_MAX = 4'd9;
    localparam logic [4:0] DEC_FIX   = 5'd6;

    // Nine's complement of one decimal digit.
    function automatic logic [3:0] nines_of(input logic [3:0] d);
        return DIGIT_MAX - d;
    endfunction

endpackage

// File: rtl/bcd_digit_add.sv
module bcd_digit_add
    import bcd_addsub_pkg::*;
(
    input  logic [3:0] a_dig,
    input  logic [3:0] b_dig,
    input  logic       c_in,
    output logic [3:0] s_dig,
    output logic       c_out
);

    logic [4:0] bin_sum;
    logic [4:0] fixed_sum;
    logic       needs_fix;

    always_comb begin
        bin_sum   = {1'b0, a_dig} + {1'b0, b_dig} + {4'b0000, c_in};
        // Above nine, or a binary carry out of the nibble.
        needs_fix = (bin_sum > {1'b0, DIGIT_MAX}) || bin_sum[4];
        fixed_sum = bin_sum + DEC_FIX;
        s_dig     = needs_fix ? fixed_sum[3:0] : bin_sum[3:0];
        c_out     = needs_fix;
    end

endmodule

// File: rtl/bcd_addsub_ctrl.sv
module bcd_addsub_ctrl
    import bcd_addsub_pkg::*;
#(
    parameter int DIGITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic recomp_needed,
    output logic load,
    output logic step,
    output logic recomp,
    output logic last,
    output logic commit,
    output logic done
);

    localparam int CW = (DIGITS > 1) ? $clog2(DIGITS) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(DIGITS - 1);

    seq_state_t    state, state_nx;
    logic [CW-1:0] idx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) state_nx = ST_MAIN_PASS;
            end
            ST_MAIN_PASS: begin
                if (last) state_nx = recomp_needed ? ST_RECOMP_PASS : ST_IDLE;
            end
            ST_RECOMP_PASS: begin
                if (last) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Digit index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (state == ST_IDLE || last) begin
            idx <= '0;
        end else begin
            idx <= idx + CW'(1);
        end
    end

    // Outputs
    always_comb begin
        load   = 1'b0;
        step   = 1'b0;
        recomp = 1'b0;
        commit = 1'b0;
        last   = (idx == LAST_IDX);
        unique case (state)
            ST_IDLE: begin
                load = start;
                last = 1'b0;
            end
            ST_MAIN_PASS: begin
                step   = 1'b1;
                commit = last && !recomp_needed;
            end
            ST_RECOMP_PASS: begin
                step   = 1'b1;
                recomp = 1'b1;
                commit = last;
            end
            default: last = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= commit;
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !last) |=> $stable(state));

    // R4
    recomp_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MAIN_PASS && last && recomp_needed) |=>
            (state == ST_RECOMP_PASS && idx == '0));

endmodule

// File: rtl/bcd_addsub_dp.sv
module bcd_addsub_dp
    import bcd_addsub_pkg::*;
#(
    parameter int DIGITS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  step,
    input  logic                  recomp,
    input  logic                  last,
    input  logic                  commit,
    input  logic                  sub,
    input  logic [4*DIGITS-1:0]   opa,
    input  logic [4*DIGITS-1:0]   opb,
    output logic                  recomp_needed,
    output logic [4*DIGITS-1:0]   result,
    output logic                  negative,
    output logic                  overflow
);

    localparam int W = 4 * DIGITS;

    logic [W-1:0] a_sh;
    logic [W-1:0] b_sh;
    logic         carry;
    logic         sub_q;
    logic [3:0]   dig_a, dig_b, dig_s;
    logic         dig_co;
    logic [W-1:0] b_next;

    always_comb begin
        dig_a  = recomp ? 4'd0 : a_sh[3:0];
        dig_b  = (sub_q || recomp) ? nines_of(b_sh[3:0]) : b_sh[3:0];
        b_next = {dig_s, b_sh[W-1:4]};
    end

    bcd_digit_add u_digit (
        .a_dig (dig_a),
        .b_dig (dig_b),
        .c_in  (carry),
        .s_dig (dig_s),
        .c_out (dig_co)
    );

    assign recomp_needed = sub_q && !dig_co;

    // Operand and partial-result shifters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_sh  <= '0;
            b_sh  <= '0;
            carry <= 1'b0;
            sub_q <= 1'b0;
        end else if (load) begin
            a_sh  <= opa;
            b_sh  <= opb;
            carry <= sub;
            sub_q <= sub;
        end else if (step) begin
            a_sh  <= a_sh >> 4;
            b_sh  <= b_next;
            carry <= (last && !recomp) ? 1'b1 : dig_co;
        end
    end

    // Result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result   <= '0;
            negative <= 1'b0;
            overflow <= 1'b0;
        end else if (commit) begin
            result   <= b_next;
            negative <= recomp;
            overflow <= !recomp && !sub_q && dig_co;
        end
    end

    // R1
    digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (dig_s <= DIGIT_MAX));

    // R6
    sub_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && sub_q) |=> !overflow);

    // R3
    main_commit_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !recomp) |=> !negative);

    for (genvar g = 0; g < DIGITS; g++) begin : g_res_chk
        // R1
        res_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            commit |=> (result[4*g +: 4] <= DIGIT_MAX));
    end

endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub
    import bcd_addsub_pkg::*;
#(
    parameter int DIGITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                sub,
    input  logic [4*DIGITS-1:0] opa,
    input  logic [4*DIGITS-1:0] opb,
    output logic [4*DIGITS-1:0] result,
    output logic                negative,
    output logic                overflow,
    output logic                done
);

    logic load, step, recomp, last, commit, recomp_needed;

    bcd_addsub_ctrl #(.DIGITS(DIGITS)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .recomp_needed (recomp_needed),
        .load          (load),
        .step          (step),
        .recomp        (recomp),
        .last          (last),
        .commit        (commit),
        .done          (done)
    );

    bcd_addsub_dp #(.DIGITS(DIGITS)) u_dp (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (load),
        .step          (step),
        .recomp        (recomp),
        .last          (last),
        .commit        (commit),
        .sub           (sub),
        .opa           (opa),
        .opb           (opb),
        .recomp_needed (recomp_needed),
        .result        (result),
        .negative      (negative),
        .overflow      (overflow)
    );

    // R9
    neg_ovf_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(negative && overflow));

endmodule

// File: tb/bcd_addsub_tb.sv
`timescale 1ns/1ps
module bcd_addsub_tb;

    localparam int ND = 8;
    localparam int W  = 4 * ND;
    localparam longint LIMIT = 64'd100000000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         sub = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic [W-1:0] result;
    logic         negative, overflow, done;

    int total = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    bcd_addsub #(.DIGITS(ND)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .sub(sub),
        .opa(opa), .opb(opb), .result(result),
        .negative(negative), .overflow(overflow), .done(done)
    );

    function automatic logic [W-1:0] to_bcd(input longint x);
        logic [W-1:0] v = '0;
        longint t = x;
        for (int i = 0; i < ND; i++) begin
            v[4*i +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return v;
    endfunction

    function automatic longint to_int(input logic [W-1:0] v);
        longint r = 0;
        for (int i = ND - 1; i >= 0; i--) r = r * 10 + longint'(v[4*i +: 4]);
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference model: decimal integer arithmetic and a cycle count.
    task automatic run_op(input longint a, input longint b, input bit s,
                          input bit poke, input string req);
        longint ev, sum;
        bit     eneg = 0, eovf = 0;
        int     lat = 8;
        if (!s) begin
            sum  = a + b;
            eovf = (sum >= LIMIT);
            ev   = sum % LIMIT;
        end else if (a >= b) begin
            ev = a - b;
        end else begin
            ev = b - a; eneg = 1; lat = 16;
        end
        opa = to_bcd(a); opb = to_bcd(b); sub = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 1; i <= lat + 2; i++) begin
            if (poke && i == 3) begin
                // R8: a second start mid-run with other operands
                opa = to_bcd(7); opb = to_bcd(3); sub = ~s; start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            chk(done == (i == lat), (lat == 16) ? "R4" : "R7", "done",
                longint'(done), longint'(i == lat));
            if (i == lat) begin
                chk(result == to_bcd(ev), req, "result", to_int(result), ev);
                chk(negative == eneg, req, "negative", longint'(negative), longint'(eneg));
                chk(overflow == eovf, req, "overflow", longint'(overflow), longint'(eovf));
            end
            if (i == lat + 2) begin
                // R9: held after completion
                chk(result == to_bcd(ev) && negative == eneg, "R9", "hold",
                    to_int(result), ev);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(result == '0, "R9", "reset result", to_int(result), 0);
        chk(!negative && !overflow, "R9", "reset flags",
            longint'({negative, overflow}), 0);
        chk(!done, "R9", "reset done", longint'(done), 0);

        run_op(12345678, 11111111, 0, 0, "R1");
        run_op(55555555, 55555555, 0, 0, "R1");
        run_op(99999999, 1, 0, 0, "R2");
        run_op(50000000, 50000000, 0, 0, "R6");
        run_op(0, 0, 0, 0, "R7");
        run_op(25, 13, 1, 0, "R3");
        run_op(99999999, 0, 1, 0, "R3");
        run_op(10000000, 1, 1, 0, "R3");
        run_op(13, 25, 1, 0, "R4");
        run_op(0, 99999999, 1, 0, "R4");
        run_op(1, 10000000, 1, 0, "R4");
        run_op(4321, 4321, 1, 0, "R5");
        run_op(0, 0, 1, 0, "R5");
        run_op(40000000, 2, 0, 1, "R8");
        run_op(5, 900, 1, 1, "R8");
        for (int k = 0; k < 40; k++) begin
            longint ra = longint'($urandom % 32'd100000000);
            longint rb = (k % 4 == 0) ? ra + longint'($urandom % 32'd3) % LIMIT
                                      : longint'($urandom % 32'd100000000);
            if (rb >= LIMIT) rb = LIMIT - 1;
            run_op(ra, rb, bit'(k % 2), 0, (k % 2) ? "R3" : "R6");
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule